// File: doc/BRIEF.md
# Per-Pin GPIO Mode Decoder

This block turns the configuration nibble of each pin of a general-purpose I/O port into the control signals of that pin's pad. It decodes the nibble, the pin's output latch bit and the value an on-chip peripheral wants to drive. From these it produces output-enable, the driven value, an open-drain flag, pull-up and pull-down enables, digital input enable and a 2-bit speed code. It also gates the pad level that feeds the port's input data register. A parameter sets the number of pins, and each pin has its own identical decoder slice.

All results are registered once, so the pad controls and the input data bit follow a change of configuration, latch, peripheral value or pad level one clock later. Analog mode isolates the pin completely: the pin does not drive, there are no pulls, and the input bit reads 0. In pull mode, the latch bit chooses the pull direction instead of the driven value.

Top module: `gpio_port_modes`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge, so a change on any input becomes visible exactly one cycle later.
- R3: Pin i uses the nibble `cfg_word[4i+3:4i]`. Bits [1:0] are the mode field and bits [3:2] the config field. A mode field of 00 makes the pin an input.
- R4: Nibble 0000 (analog) gives output-enable 0, input enable 0, both pulls off and an input data bit of 0, whatever the pad level is.
- R5: Input mode with config field 01 (floating), or with the reserved 11, gives input enable 1, no pulls, no drive, and an input data bit equal to the pad level.
- R6: Input mode with config field 10 turns on pull-up when the latch bit is 1 and pull-down when it is 0, never both. The input data bit follows the pad.
- R7: In every output mode (mode field 01, 10 or 11), input enable is 1, both pulls are off and the input data bit follows the pad level.
- R8: Output mode with config field 00 or 10 is push-pull: output-enable 1, open-drain flag 0, and the pad value equals the selected value.
- R9: Output mode with config field 01 or 11 is open-drain: the open-drain flag is 1, output-enable is 1 only when the selected value is 0, and the pad value is always 0.
- R10: The selected value is `alt_out` when config bit [3] is 1 (alternate function) and `out_latch` when it is 0.
- R11: The speed code equals the mode field in output modes (01 = 10 MHz, 10 = 2 MHz, 11 = 50 MHz) and is 00 in input modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 4*NPINS | Configuration nibble for each pin |
| out_latch | input | NPINS | Output latch bit for each pin |
| alt_out | input | NPINS | Peripheral output value for each pin |
| pad_in | input | NPINS | Sampled pad level for each pin |
| pad_oe | output | NPINS | Pad driver enable |
| pad_out | output | NPINS | Value driven when enabled |
| pad_od | output | NPINS | Open-drain mode flag |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |
| pad_ie | output | NPINS | Digital input buffer enable |
| pad_speed | output | 2*NPINS | Speed code for each pin |
| in_data | output | NPINS | Gated pad level for the input data register |

## Verification
Every result passes through a single register stage, so each one is due one cycle after its inputs change. The bench drives inputs on the falling edge and computes the expected pad controls from its own behavioural model. It then compares all outputs on the next falling edge, after the one rising edge that captures them. Directed vectors cover each of the sixteen nibbles with both latch values, both peripheral values and both pad levels. Random vectors then change configuration and data on every cycle, so a stale value or an extra cycle of delay shows up as a miscompare.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;

    localparam int CFG_W  = 4;
    localparam int SPD_W  = 2;

    localparam logic [1:0] MODE_IN   = 2'b00;
    localparam logic [1:0] CNF_ANA   = 2'b00;
    localparam logic [1:0] CNF_PULL  = 2'b10;

    typedef struct packed {
        logic             oe;
        logic             out;
        logic             od;
        logic             pu;
        logic             pd;
        logic             ie;
        logic [SPD_W-1:0] spd;
    } pad_ctrl_t;

endpackage

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
    import gpio_mode_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             latch,
    input  logic             alt_val,
    output pad_ctrl_t        ctrl
);
    logic [1:0] mode;
    logic [1:0] cnf;
    logic       sel_val;

    assign mode = cfg[1:0];
    assign cnf  = cfg[3:2];

    always_comb begin
        ctrl    = '0;
        sel_val = cnf[1] ? alt_val : latch;
        if (mode == MODE_IN) begin
            unique case (cnf)
                CNF_ANA: begin
                    ctrl.ie = 1'b0;
                end
                CNF_PULL: begin
                    ctrl.ie = 1'b1;
                    ctrl.pu = latch;
                    ctrl.pd = ~latch;
                end
                default: begin
                    ctrl.ie = 1'b1;
                end
            endcase
        end else begin
            ctrl.ie  = 1'b1;
            ctrl.spd = mode;
            ctrl.od  = cnf[0];
            if (cnf[0]) begin
                ctrl.oe  = ~sel_val;
                ctrl.out = 1'b0;
            end else begin
                ctrl.oe  = 1'b1;
                ctrl.out = sel_val;
            end
        end
    end

endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense (
    input  logic in_en,
    input  logic pad,
    output logic in_bit
);
    assign in_bit = in_en & pad;
endmodule

// File: rtl/gpio_port_modes.sv
module gpio_port_modes
    import gpio_mode_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CFG_W*NPINS-1:0] cfg_word,
    input  logic [NPINS-1:0]       out_latch,
    input  logic [NPINS-1:0]       alt_out,
    input  logic [NPINS-1:0]       pad_in,
    output logic [NPINS-1:0]       pad_oe,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_od,
    output logic [NPINS-1:0]       pad_pu,
    output logic [NPINS-1:0]       pad_pd,
    output logic [NPINS-1:0]       pad_ie,
    output logic [SPD_W*NPINS-1:0] pad_speed,
    output logic [NPINS-1:0]       in_data
);
    typedef struct packed {
        pad_ctrl_t [NPINS-1:0] ctl;
        logic      [NPINS-1:0] din;
    } port_t;

    pad_ctrl_t [NPINS-1:0] ctl_w;
    logic      [NPINS-1:0] din_w;
    port_t                 port_d;
    port_t                 port_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_decode u_dec (
            .cfg     (cfg_word[CFG_W*i +: CFG_W]),
            .latch   (out_latch[i]),
            .alt_val (alt_out[i]),
            .ctrl    (ctl_w[i])
        );
        gpio_pin_sense u_sense (
            .in_en  (ctl_w[i].ie),
            .pad    (pad_in[i]),
            .in_bit (din_w[i])
        );
    end

    always_comb begin
        port_d     = port_q;
        port_d.ctl = ctl_w;
        port_d.din = din_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            pad_oe[i]                  = port_q.ctl[i].oe;
            pad_out[i]                 = port_q.ctl[i].out;
            pad_od[i]                  = port_q.ctl[i].od;
            pad_pu[i]                  = port_q.ctl[i].pu;
            pad_pd[i]                  = port_q.ctl[i].pd;
            pad_ie[i]                  = port_q.ctl[i].ie;
            pad_speed[SPD_W*i +: SPD_W] = port_q.ctl[i].spd;
        end
        in_data = port_q.din;
    end

endmodule

// File: rtl/gpio_port_modes_chk.sv
module gpio_port_modes_chk #(
    parameter int NPINS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [4*NPINS-1:0]   cfg_word,
    input logic [NPINS-1:0]     out_latch,
    input logic [NPINS-1:0]     alt_out,
    input logic [NPINS-1:0]     pad_in,
    input logic [NPINS-1:0]     pad_oe,
    input logic [NPINS-1:0]     pad_out,
    input logic [NPINS-1:0]     pad_od,
    input logic [NPINS-1:0]     pad_pu,
    input logic [NPINS-1:0]     pad_pd,
    input logic [NPINS-1:0]     pad_ie,
    input logic [2*NPINS-1:0]   pad_speed,
    input logic [NPINS-1:0]     in_data
);
    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert ((pad_oe | pad_pu | pad_pd | pad_ie | in_data) == '0); // R1
        end
    end

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0); // R6

    AST_NO_PULL_WHEN_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu | pad_pd) & pad_oe) == '0); // R7

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_od & pad_out) == '0); // R9

    AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data & ~pad_ie) == '0); // R4

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        AST_PULL_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_word[4*i +: 4] == 4'b1000) |=>
            (pad_pu[i] == $past(out_latch[i]) && pad_pd[i] == !$past(out_latch[i]))); // R6

        AST_ANALOG_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_word[4*i +: 4] == 4'b0000) |=>
            (!pad_oe[i] && !pad_ie[i] && !in_data[i])); // R4

        AST_OUTPUT_FOLLOWS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_word[4*i +: 2] != 2'b00) |=>
            (in_data[i] == $past(pad_in[i]) && pad_speed[2*i +: 2] == $past(cfg_word[4*i +: 2]))); // R7 R11
    end

endmodule

bind gpio_port_modes gpio_port_modes_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_word),
    .out_latch (out_latch),
    .alt_out   (alt_out),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_od    (pad_od),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .pad_ie    (pad_ie),
    .pad_speed (pad_speed),
    .in_data   (in_data)
);

// File: tb/gpio_port_modes_bench.sv
module gpio_port_modes_bench;
    localparam int  NPINS  = 16;
    localparam time CLK_PER = 10ns;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [4*NPINS-1:0]   cfg_word = '0;
    logic [NPINS-1:0]     out_latch = '0;
    logic [NPINS-1:0]     alt_out = '0;
    logic [NPINS-1:0]     pad_in = '0;
    logic [NPINS-1:0]     pad_oe, pad_out, pad_od, pad_pu, pad_pd, pad_ie, in_data;
    logic [2*NPINS-1:0]   pad_speed;

    int n_vec  = 0;
    int n_fail = 0;

    // expected values, one entry per pin
    int e_oe[NPINS], e_out[NPINS], e_od[NPINS], e_pu[NPINS];
    int e_pd[NPINS], e_ie[NPINS], e_spd[NPINS], e_in[NPINS];

    always #(CLK_PER/2) clk = ~clk;

    gpio_port_modes #(.NPINS(NPINS)) u_gpio_port_modes (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .out_latch(out_latch),
        .alt_out(alt_out), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ie(pad_ie),
        .pad_speed(pad_speed), .in_data(in_data)
    );

    task automatic cmp(input string tag, input int p, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s pin %0d: actual %0d expected %0d", tag, p, act, exp);
        end
    endtask

    // behavioural model of one pin: R3 layout, modes R4..R11
    task automatic model(input int p);
        int nib, md, cf, v, lt, pd;
        nib = int'(cfg_word[4*p +: 4]);
        md  = nib % 4;
        cf  = nib / 4;
        lt  = int'(out_latch[p]);
        pd  = int'(pad_in[p]);
        e_oe[p] = 0; e_out[p] = 0; e_od[p] = 0; e_pu[p] = 0;
        e_pd[p] = 0; e_ie[p] = 1; e_spd[p] = 0; e_in[p] = pd;
        if (md == 0) begin
            if (cf == 0) begin
                e_ie[p] = 0;
                e_in[p] = 0;
            end else if (cf == 2) begin
                if (lt == 1) e_pu[p] = 1;
                else         e_pd[p] = 1;
            end
        end else begin
            v = (cf >= 2) ? int'(alt_out[p]) : lt;
            e_spd[p] = md;
            if (cf == 1 || cf == 3) begin
                e_od[p] = 1;
                e_oe[p] = (v == 0) ? 1 : 0;
            end else begin
                e_oe[p]  = 1;
                e_out[p] = v;
            end
        end
    endtask

    task automatic check_all();
        for (int p = 0; p < NPINS; p++) begin
            cmp("R8 R9 oe",      p, int'(pad_oe[p]),  e_oe[p]);
            cmp("R10 R8 out",    p, int'(pad_out[p]), e_out[p]);
            cmp("R9 od",         p, int'(pad_od[p]),  e_od[p]);
            cmp("R6 pu",         p, int'(pad_pu[p]),  e_pu[p]);
            cmp("R6 pd",         p, int'(pad_pd[p]),  e_pd[p]);
            cmp("R5 ie",         p, int'(pad_ie[p]),  e_ie[p]);
            cmp("R11 speed",     p, int'(pad_speed[2*p +: 2]), e_spd[p]);
            cmp("R4 R7 in_data", p, int'(in_data[p]), e_in[p]);
        end
    endtask

    // R2: apply on falling edge, expected value is due at the next falling edge
    task automatic step(input logic [4*NPINS-1:0] c, input logic [NPINS-1:0] l,
                        input logic [NPINS-1:0] a, input logic [NPINS-1:0] d);
        cfg_word  = c;
        out_latch = l;
        alt_out   = a;
        pad_in    = d;
        for (int p = 0; p < NPINS; p++) model(p);
        @(negedge clk);
        check_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : stim
        logic [4*NPINS-1:0] c;
        cfg_word  = {NPINS{4'b0100}};
        out_latch = '1;
        alt_out   = '1;
        pad_in    = '1;
        repeat (3) @(negedge clk);
        // R1: all outputs quiet during reset
        for (int p = 0; p < NPINS; p++) begin
            cmp("R1 oe", p, int'(pad_oe[p]), 0);
            cmp("R1 ie", p, int'(pad_ie[p]), 0);
            cmp("R1 in_data", p, int'(in_data[p]), 0);
            cmp("R1 pull", p, int'(pad_pu[p] | pad_pd[p]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R3: pin i uses nibble i; each pin gets nibble (i+k) mod 16
        for (int k = 0; k < 16; k++) begin
            for (int pat = 0; pat < 4; pat++) begin
                for (int p = 0; p < NPINS; p++) c[4*p +: 4] = 4'((p + k) % 16);
                step(c, (pat[0] ? 16'hA5C3 : 16'h5A3C), (pat[1] ? 16'hF00F : 16'h0FF0),
                     (pat[0] ^ pat[1]) ? 16'hFFFF : 16'h3333);
            end
        end
        // R2: random changes every cycle expose any extra or missing delay
        for (int n = 0; n < 400; n++) begin
            step({$urandom, $urandom}, 16'($urandom), 16'($urandom), 16'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule